// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Controller

This block watches a bank of 27 asynchronous input pins for level changes. The pins are split into four groups of up to eight pins. Every pin first passes through a two-flop synchronizer. A change is any difference between the synchronized value and its value one clock earlier, so rising and falling transitions both count. Each pin has its own mask bit. A change on a pin whose mask bit is set raises the pending flag of that pin's group.

A group asks the CPU for service only when three bits are all one: the group's pending flag, the group's enable bit and the global interrupt enable input. When more than one group qualifies, a small two-state request machine reports the lowest-numbered one. It drives a single request line and a 2-bit vector index. A flag is cleared in one of two ways. Software can write one to the flag's bit, or the CPU can present an acknowledge that carries the group's vector index. If a new change arrives in the same cycle as a clear, the flag stays set.

The request machine has two states. In ST_IDLE no group qualifies and the request line is low. In ST_ACTIVE at least one group qualifies, the request line is high and the vector index tracks the winning group. The transition "raise" goes from ST_IDLE to ST_ACTIVE when any group qualifies. The transition "drop" goes from ST_ACTIVE to ST_IDLE when no group qualifies. ST_ACTIVE stays in place while at least one group still qualifies, and ST_IDLE stays in place while none does.

Top module: `pcg_pinchg_irq`

## Requirements
- R1: After reset, every register reads zero, and `irq_req` and `irq_vec` are zero.
- R2: Pin p belongs to group p/8. Group 3 holds only pins 24, 25 and 26, at bits 0 to 2 of its mask register. Mask register g sits at bus address 2+g. Bit b of that register enables pin 8g+b.
- R3: A rising or a falling change on a pin whose mask bit is one sets its group's flag, which reads at bus address 1, bit g. A change on a pin whose mask bit is zero leaves every flag unchanged.
- R4: `irq_req` is one exactly when some group has its flag set, its enable bit set and `gie` is high. The enable bit for group g is bit g of the control register at address 0. The request line follows that condition with one clock of delay.
- R5: Writing to address 1 clears each flag whose data bit is one. A data bit of zero leaves its flag unchanged.
- R6: An acknowledge (`ack_valid` high with `ack_vec` = g) clears flag g at the next clock edge. The other flags are unchanged.
- R7: If a qualifying change and a clear (a write-one or an acknowledge) reach the same flag in the same cycle, the flag stays one.
- R8: When several groups qualify, `irq_vec` gives the lowest-numbered qualifying group.
- R9: Reserved bits are ignored on write and always read zero: control bits 7:4, flag bits 7:4 and group-3 mask bits 7:3.
- R10: A pin change that is set up before clock edge 1 sets the flag at edge 3. With the group enabled and `gie` high, `irq_req` rises at edge 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | 27 | Monitored pins, asynchronous |
| gie | input | 1 | Global interrupt enable |
| ack_valid | input | 1 | CPU acknowledge strobe |
| ack_vec | input | 2 | Group index being acknowledged |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, single cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on address |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 2 | Index of the winning group |

## Verification
The set path and the clear path can both act on the same flag at the same clock edge. A synchronized pin change can land in the cycle where software writes one to that flag. It can also land in the cycle where the CPU acknowledges that group. To provoke this, the bench first sets the flag, then toggles a masked pin. It counts clock edges so that the write-one or the acknowledge is presented exactly in the cycle where the change is detected. The flag must read one afterwards. Separate tests, with no change pending, check that each clear path on its own does clear the flag.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_FLAG  = 3'd1;
    localparam int                A_MASK0 = 2;

    typedef enum logic {
        ST_IDLE,
        ST_ACTIVE
    } rq_state_t;

    // bits of group g's mask register that map onto a real pin
    function automatic logic [DATA_W-1:0] live_bits(input int n_pins, input int g);
        logic [DATA_W-1:0] v;
        v = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (g * DATA_W + i < n_pins) v[i] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/pcg_pin_sync.sv
module pcg_pin_sync #(
    parameter int NUM_PINS = 27,
    parameter int STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] chg
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic [STAGES:0] sh_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[STAGES-1:0], pin_in[p]};
        end

        assign chg[p] = sh_q[STAGES] ^ sh_q[STAGES-1];
    end

endmodule

// File: rtl/pcg_regs.sv
module pcg_regs
    import pcg_pkg::*;
#(
    parameter int NUM_PINS = 27,
    parameter int GROUPS   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wr,
    input  logic [DATA_W-1:0]          bus_wdata,
    input  logic [GROUPS-1:0]          flags,
    output logic [GROUPS-1:0]          en_o,
    output logic [GROUPS*DATA_W-1:0]   mask_o,
    output logic [GROUPS-1:0]          w1c_o,
    output logic [DATA_W-1:0]          bus_rdata
);

    localparam logic [DATA_W-1:0] GRP_LIVE = DATA_W'((1 << GROUPS) - 1);

    logic [GROUPS-1:0] en_q;
    logic [DATA_W-1:0] mask_q [GROUPS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              en_q <= '0;
        else if (bus_wr && bus_addr == A_CTRL)   en_q <= bus_wdata[GROUPS-1:0];
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_mask
        localparam logic [DATA_W-1:0]  LIVE = live_bits(NUM_PINS, g);
        localparam logic [ADDR_W-1:0]  ADR  = ADDR_W'(A_MASK0 + g);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        mask_q[g] <= '0;
            else if (bus_wr && bus_addr == ADR) mask_q[g] <= bus_wdata & LIVE;
        end

        assign mask_o[g*DATA_W +: DATA_W] = mask_q[g];

        // R9
        mask_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_addr == ADR) |-> ((bus_rdata & ~LIVE) == '0));
    end

    assign en_o  = en_q;
    assign w1c_o = (bus_wr && bus_addr == A_FLAG) ? bus_wdata[GROUPS-1:0] : '0;

    always_comb begin
        bus_rdata = '0;
        unique case (1'b1)
            (bus_addr == A_CTRL): bus_rdata[GROUPS-1:0] = en_q;
            (bus_addr == A_FLAG): bus_rdata[GROUPS-1:0] = flags;
            default: begin
                for (int g = 0; g < GROUPS; g++) begin
                    if (bus_addr == ADDR_W'(A_MASK0 + g)) bus_rdata = mask_q[g];
                end
            end
        endcase
    end

    // R9
    flag_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_FLAG || bus_addr == A_CTRL) |-> ((bus_rdata & ~GRP_LIVE) == '0));

endmodule

// File: rtl/pcg_flags.sv
module pcg_flags #(
    parameter int GROUPS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GROUPS-1:0] hit,
    input  logic [GROUPS-1:0] clr,
    output logic [GROUPS-1:0] flags
);

    logic [GROUPS-1:0] flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= hit | (flag_q & ~clr);
    end

    assign flags = flag_q;

    for (genvar g = 0; g < GROUPS; g++) begin : g_chk
        // R3 R7
        flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit[g] |=> flags[g]);
        // R5 R6
        flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[g] && !hit[g]) |=> !flags[g]);
        // R5
        flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr[g] && !hit[g]) |=> $stable(flags[g]));
    end

endmodule

// File: rtl/pcg_req_fsm.sv
module pcg_req_fsm
    import pcg_pkg::*;
#(
    parameter int GROUPS = 4,
    parameter int VEC_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GROUPS-1:0] qual,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vec
);

    rq_state_t        state_q, state_d;
    logic [VEC_W-1:0] vec_q, win;
    logic             any_q;

    assign any_q = |qual;

    always_comb begin
        win = '0;
        for (int i = GROUPS - 1; i >= 0; i--) begin
            if (qual[i]) win = VEC_W'(i);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (any_q)  state_d = ST_ACTIVE;
            ST_ACTIVE: if (!any_q) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     vec_q <= '0;
        else if (any_q) vec_q <= win;
    end

    assign irq_req = (state_q == ST_ACTIVE);
    assign irq_vec = vec_q;

    // R4
    req_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_q |=> irq_req);
    // R4
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_q |=> !irq_req);
    // R8
    prio_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        qual[0] |=> (irq_vec == '0));

endmodule

// File: rtl/pcg_pinchg_irq.sv
module pcg_pinchg_irq
    import pcg_pkg::*;
#(
    parameter int NUM_PINS    = 27,
    parameter int SYNC_STAGES = 2,
    parameter int GROUPS      = (NUM_PINS + DATA_W - 1) / DATA_W,
    parameter int VEC_W       = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                gie,
    input  logic                ack_valid,
    input  logic [VEC_W-1:0]    ack_vec,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                irq_req,
    output logic [VEC_W-1:0]    irq_vec
);

    localparam int PAD = GROUPS * DATA_W;

    logic [NUM_PINS-1:0] chg;
    logic [PAD-1:0]      chg_pad, mask_pad;
    logic [GROUPS-1:0]   hit, clr, ack_hit, w1c, en, flags, qual;

    pcg_pin_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .chg(chg)
    );

    pcg_regs #(.NUM_PINS(NUM_PINS), .GROUPS(GROUPS)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .flags(flags), .en_o(en), .mask_o(mask_pad),
        .w1c_o(w1c), .bus_rdata(bus_rdata)
    );

    for (genvar p = 0; p < PAD; p++) begin : g_pad
        if (p < NUM_PINS) begin : g_real
            assign chg_pad[p] = chg[p];
        end else begin : g_none
            assign chg_pad[p] = 1'b0;
        end
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assign hit[g]     = |(chg_pad[g*DATA_W +: DATA_W] & mask_pad[g*DATA_W +: DATA_W]);
        assign ack_hit[g] = ack_valid && (ack_vec == VEC_W'(g));

        // R6
        ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_valid && ack_vec == VEC_W'(g) && !hit[g]) |=> !flags[g]);
    end

    assign clr  = w1c | ack_hit;
    assign qual = flags & en & {GROUPS{gie}};

    pcg_flags #(.GROUPS(GROUPS)) u_flags (
        .clk(clk), .rst_n(rst_n), .hit(hit), .clr(clr), .flags(flags)
    );

    pcg_req_fsm #(.GROUPS(GROUPS), .VEC_W(VEC_W)) u_req (
        .clk(clk), .rst_n(rst_n), .qual(qual), .irq_req(irq_req), .irq_vec(irq_vec)
    );

    // R4
    gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |=> !irq_req);

endmodule

// File: tb/sim_pcg_pinchg_irq.sv
module sim_pcg_pinchg_irq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [26:0] pin_in = '0;
    logic        gie = 1'b0;
    logic        ack_valid = 1'b0;
    logic [1:0]  ack_vec = '0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq_req;
    logic [1:0]  irq_vec;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pcg_pinchg_irq u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .gie(gie),
        .ack_valid(ack_valid), .ack_vec(ack_vec), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req), .irq_vec(irq_vec)
    );

    // {pin index, mask bit, expected flags after toggle}
    localparam logic [9:0] TBL [0:9] = '{
        {5'd0,  1'b1, 4'b0001},
        {5'd7,  1'b1, 4'b0001},
        {5'd8,  1'b1, 4'b0010},
        {5'd15, 1'b0, 4'b0000},
        {5'd16, 1'b1, 4'b0100},
        {5'd23, 1'b1, 4'b0100},
        {5'd24, 1'b1, 4'b1000},
        {5'd26, 1'b1, 4'b1000},
        {5'd26, 1'b0, 4'b0000},
        {5'd12, 1'b1, 4'b0010}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] d;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d);
            chk("R1 reg reset", d, 8'h00);
        end
        chk("R1 irq_req reset", irq_req, 1'b0);
        chk("R1 irq_vec reset", irq_vec, 2'd0);

        // R9 reserved bits
        wr(3'd0, 8'hFF); rd(3'd0, d); chk("R9 ctrl reserved", d, 8'h0F);
        wr(3'd5, 8'hFF); rd(3'd5, d); chk("R9 mask3 reserved", d, 8'h07);
        wr(3'd0, 8'h00); wr(3'd5, 8'h00);
        wr(3'd1, 8'hFF); rd(3'd1, d); chk("R9 flag reserved", d, 8'h00);

        // R2 R3 table walk
        for (int i = 0; i < 10; i++) begin
            int pin;
            pin = int'(TBL[i][9:5]);
            for (int g = 0; g < 4; g++) wr(3'(2 + g), 8'h00);
            wr(3'(2 + pin / 8), 8'(TBL[i][4]) << (pin % 8));
            wr(3'd1, 8'h0F);
            @(negedge clk);
            pin_in[pin] = ~pin_in[pin];
            idle(6);
            rd(3'd1, d);
            chk($sformatf("R2 R3 table row %0d flags", i), d, {4'h0, TBL[i][3:0]});
        end

        // R10 latency and R4 request
        for (int g = 0; g < 4; g++) wr(3'(2 + g), 8'h00);
        wr(3'd2, 8'h08);
        wr(3'd0, 8'h01);
        gie = 1'b1;
        wr(3'd1, 8'h0F);
        idle(2);
        bus_addr = 3'd1;
        @(negedge clk);
        pin_in[3] = ~pin_in[3];
        @(posedge clk); @(posedge clk); #1;
        chk("R10 flag low after edge 2", bus_rdata, 8'h00);
        @(posedge clk); #1;
        chk("R10 flag set at edge 3", bus_rdata, 8'h01);
        chk("R10 no request at edge 3", irq_req, 1'b0);
        @(posedge clk); #1;
        chk("R10 R4 request at edge 4", irq_req, 1'b1);
        chk("R4 vector group 0", irq_vec, 2'd0);

        // R4 gating by gie and by enable bit
        @(negedge clk); gie = 1'b0;
        idle(2);
        chk("R4 gie low blocks request", irq_req, 1'b0);
        gie = 1'b1;
        idle(2);
        chk("R4 gie high restores request", irq_req, 1'b1);
        wr(3'd0, 8'h00);
        idle(2);
        chk("R4 enable low blocks request", irq_req, 1'b0);

        // R7 set wins over write-one-to-clear (flag 0 is set now)
        @(negedge clk);
        pin_in[3] = ~pin_in[3];
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        bus_addr = 3'd1; bus_wdata = 8'h01; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        #1 chk("R7 set beats write clear", bus_rdata, 8'h01);

        // R7 set wins over acknowledge
        pin_in[3] = ~pin_in[3];
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        ack_valid = 1'b1; ack_vec = 2'd0;
        @(negedge clk);
        ack_valid = 1'b0;
        #1 chk("R7 set beats ack clear", bus_rdata, 8'h01);

        // set flags of groups 1 and 3 for priority and clear tests
        wr(3'd3, 8'h01);
        wr(3'd5, 8'h01);
        @(negedge clk);
        pin_in[8] = ~pin_in[8];
        pin_in[24] = ~pin_in[24];
        idle(6);
        rd(3'd1, d);
        chk("R3 groups 0 1 3 set", d, 8'h0B);

        // R5 write zero does nothing, write one clears only its bit
        wr(3'd1, 8'h00); rd(3'd1, d); chk("R5 write zero keeps flags", d, 8'h0B);
        wr(3'd1, 8'h01); rd(3'd1, d); chk("R5 clear bit 0 only", d, 8'h0A);

        // R8 priority
        wr(3'd0, 8'h0F);
        idle(2);
        chk("R8 request high", irq_req, 1'b1);
        chk("R8 lowest group wins", irq_vec, 2'd1);

        // R6 acknowledge clears group 1, then group 3 wins
        @(negedge clk);
        ack_valid = 1'b1; ack_vec = 2'd1;
        @(negedge clk);
        ack_valid = 1'b0;
        rd(3'd1, d);
        chk("R6 ack clears only group 1", d, 8'h08);
        idle(2);
        chk("R8 next group wins", irq_vec, 2'd3);

        @(negedge clk);
        ack_valid = 1'b1; ack_vec = 2'd3;
        @(negedge clk);
        ack_valid = 1'b0;
        rd(3'd1, d);
        chk("R6 ack clears group 3", d, 8'h00);
        idle(2);
        chk("R4 request drops with no flags", irq_req, 1'b0);

        finish_run();
    end

endmodule